// File: doc/BRIEF.md
# Two-Wire Serial Memory Target Engine

This block is the target side of a two-wire serial memory. It oversamples the SCL and SDA lines on the system clock, recognises start and stop conditions, and drives SDA low through an open-drain enable. Each transaction opens with a device address byte that carries a read/write flag. A write transaction then carries two word-address bytes and any number of data bytes. A read transaction shifts out bytes from a synchronous RAM port and keeps going for as long as the host acknowledges.

A single word pointer persists between transactions. Reads advance it across the whole array. Writes advance it only inside the current 64-byte page. Every received data byte goes to a separate page-write unit together with its address, and a commit pulse follows the closing stop. While that unit reports a write in progress, the block stays silent, so the host can poll with device address bytes until one is acknowledged.

Top module: `twi_mem_target`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Either condition arriving in the middle of a byte abandons that byte and releases SDA. After a start the block expects a fresh device address byte. After a stop it ignores the bus until the next start.
- R2: The device address byte, sent MSB first, is accepted only if bits 7:4 are 1010, bit 3 is 0 and bits 2:1 equal `strap_i`. Bit 0 set to 1 selects a read. On a mismatch the block gives no acknowledge and ignores all further bytes until a start.
- R3: An accepted byte is acknowledged by holding SDA low during the ninth clock. The drive begins after the SCL falling edge that ends the eighth bit and is released after the falling edge of the ninth clock.
- R4: A write transaction takes a high address byte and then a low address byte. Bits 6:0 of the high byte and all of the low byte form the 15-bit pointer. Bit 7 of the high byte has no effect.
- R5: Each data byte of a write is presented for one cycle on `wr_valid`, with `wr_addr` equal to the pointer. The pointer then steps by one in bits 5:0 only, so 0x0A3F is followed by 0x0A00.
- R6: A stop that closes a write carrying at least one data byte produces a one-cycle `wr_commit`. A stop after only address bytes does not.
- R7: The pointer keeps its value between transactions. A read that starts without setting an address returns the byte after the last one read or written.
- R8: A read shifts out the byte at the pointer, MSB first, and then advances the pointer by one across the whole array, so 0x7FFF is followed by 0x0000. The read continues while the host acknowledges each byte.
- R9: A host not-acknowledge ends the read. SDA is released, and any further clocks before a start read back as 1.
- R10: A random read is a write transaction that sends only the two address bytes, followed by a repeated start and a read-type device address. It returns data from the address that was just set.
- R11: While `busy_i` is high at the end of a device address byte, that byte gets no acknowledge, whether it requests a read or a write.
- R12: `sda_oe` rises only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the wire |
| strap_i | input | STRAP_W | Hardwired select bits matched against address bits 2:1 |
| busy_i | input | 1 | Page-write unit is in its internal write cycle |
| sda_oe | output | 1 | 1 pulls SDA low |
| rd_addr | output | ADDR_W | Synchronous RAM read address (the pointer) |
| rd_data | input | 8 | RAM read data, one cycle after `rd_addr` |
| wr_valid | output | 1 | A received data byte is presented |
| wr_addr | output | ADDR_W | Address of that byte |
| wr_data | output | 8 | The byte itself |
| wr_commit | output | 1 | A stop closed a write that carried data |

## Verification
Two decisions can land on the same byte boundary: the page-write unit's busy flag and the device address decision. The bench sends a poll right after a write's stop, while busy is certainly high, and expects no acknowledge. It keeps polling until the flag clears and then expects an acknowledge followed by correct data. A second overlap happens on a read, where the pointer advance falls on the eighth bit of the byte being shifted out. Scoreboarded readbacks across the 0x7FFF boundary and across a page wrap show whether the next byte was fetched from the new pointer and not from a stale one.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_AHI, ST_ALO, ST_WDAT, ST_RDAT
  } twi_st_e;

  localparam logic [3:0] DEV_TAG  = 4'b1010;
  localparam logic [3:0] ACK_SLOT = 4'd8;
  localparam logic [3:0] LAST_BIT = 4'd7;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_m, scl_p, sda_m, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 1'b1; scl_q <= 1'b1; scl_p <= 1'b1;
      sda_m <= 1'b1; sda_q <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_m <= scl_i; scl_q <= scl_m; scl_p <= scl_q;
      sda_m <= sda_i; sda_q <= sda_m; sda_p <= sda_q;
    end
  end

  assign scl_rise  = scl_q & ~scl_p;
  assign scl_fall  = ~scl_q & scl_p;
  assign start_evt = scl_q & scl_p & sda_p & ~sda_q;
  assign stop_evt  = scl_q & scl_p & ~sda_p & sda_q;
endmodule

// File: rtl/twi_addr_ctr.sv
module twi_addr_ctr #(
  parameter int ADDR_W = 15,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc_rd,
  input  logic              inc_wr,
  output logic [ADDR_W-1:0] ptr
);
  function automatic logic [ADDR_W-1:0] next_rd(input logic [ADDR_W-1:0] p);
    return p + 1'b1;
  endfunction

  function automatic logic [ADDR_W-1:0] next_wr(input logic [ADDR_W-1:0] p);
    logic [PAGE_W-1:0] low;
    low = p[PAGE_W-1:0] + 1'b1;
    return {p[ADDR_W-1:PAGE_W], low};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr <= '0;
    else if (load)   ptr <= load_val;
    else if (inc_wr) ptr <= next_wr(ptr);
    else if (inc_rd) ptr <= next_rd(ptr);
  end
endmodule

// File: rtl/twi_mem_target.sv
module twi_mem_target
  import twi_mem_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int PAGE_W  = 6,
  parameter int STRAP_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               busy_i,
  output logic               sda_oe,
  output logic [ADDR_W-1:0]  rd_addr,
  input  logic [7:0]         rd_data,
  output logic               wr_valid,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [7:0]         wr_data,
  output logic               wr_commit
);
  localparam int HI_W = ADDR_W - 8;

  function automatic logic dev_match(input logic [7:0] b, input logic [STRAP_W-1:0] s);
    return (b[7:4] == DEV_TAG) && (b[3:1] == 3'(s));
  endfunction

  logic scl_q, sda_q, scl_rise, scl_fall, start_evt, stop_evt;
  twi_st_e st;
  logic [3:0] bit_cnt;
  logic [7:0] rx, tx, byte_in;
  logic ack_q, rw_q, wseen;
  logic [HI_W-1:0] hi_q;
  logic [ADDR_W-1:0] ptr;
  logic byte_end, ptr_load, ptr_inc_rd, ptr_inc_wr;

  twi_line_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  assign byte_in    = {rx[6:0], sda_q};
  assign byte_end   = scl_rise && (bit_cnt == LAST_BIT) && (st != ST_IDLE)
                      && !start_evt && !stop_evt;
  assign ptr_load   = byte_end && (st == ST_ALO);
  assign ptr_inc_wr = byte_end && (st == ST_WDAT);
  assign ptr_inc_rd = byte_end && (st == ST_RDAT);

  twi_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val({hi_q, byte_in}),
    .inc_rd(ptr_inc_rd), .inc_wr(ptr_inc_wr), .ptr(ptr)
  );

  assign rd_addr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; bit_cnt <= '0; rx <= '0; tx <= '0;
      ack_q <= 1'b0; rw_q <= 1'b0; hi_q <= '0; wseen <= 1'b0;
      sda_oe <= 1'b0; wr_valid <= 1'b0; wr_addr <= '0; wr_data <= '0;
      wr_commit <= 1'b0;
    end else begin
      wr_valid  <= 1'b0;
      wr_commit <= 1'b0;
      if (start_evt) begin
        st <= ST_DEV; bit_cnt <= '0; sda_oe <= 1'b0; ack_q <= 1'b0; wseen <= 1'b0;
      end else if (stop_evt) begin
        st <= ST_IDLE; bit_cnt <= '0; sda_oe <= 1'b0;
        wr_commit <= wseen; wseen <= 1'b0;
      end else if (st != ST_IDLE) begin
        if (scl_rise) begin
          if (bit_cnt == ACK_SLOT) begin
            bit_cnt <= '0;
            case (st)
              ST_DEV:  st <= !ack_q ? ST_IDLE : (rw_q ? ST_RDAT : ST_AHI);
              ST_AHI:  st <= ST_ALO;
              ST_ALO:  st <= ST_WDAT;
              ST_RDAT: st <= sda_q ? ST_IDLE : ST_RDAT;
              default: st <= st;
            endcase
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
            rx      <= byte_in;
            if (bit_cnt == LAST_BIT) begin
              case (st)
                ST_DEV: begin
                  ack_q <= dev_match(byte_in, strap_i) && !busy_i;
                  rw_q  <= byte_in[0];
                end
                ST_AHI: begin ack_q <= 1'b1; hi_q <= byte_in[HI_W-1:0]; end
                ST_ALO: ack_q <= 1'b1;
                ST_WDAT: begin
                  ack_q <= 1'b1; wr_valid <= 1'b1; wr_addr <= ptr;
                  wr_data <= byte_in; wseen <= 1'b1;
                end
                default: ack_q <= 1'b0;
              endcase
            end
          end
        end else if (scl_fall) begin
          if (bit_cnt == ACK_SLOT) begin
            sda_oe <= ack_q && (st != ST_RDAT);
          end else if (st == ST_RDAT) begin
            if (bit_cnt == '0) begin
              tx     <= {rd_data[6:0], 1'b0};
              sda_oe <= ~rd_data[7];
            end else begin
              tx     <= {tx[6:0], 1'b0};
              sda_oe <= ~tx[7];
            end
          end else begin
            sda_oe <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/twi_mem_target_chk.sv
module twi_mem_target_chk #(
  parameter int ADDR_W = 15,
  parameter int PAGE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_q,
  input logic              start_evt,
  input logic              stop_evt,
  input logic              sda_oe,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              wr_commit
);
  logic have_prev;
  logic [ADDR_W-1:0] prev_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev <= 1'b0; prev_addr <= '0;
    end else if (start_evt) begin
      have_prev <= 1'b0;
    end else if (wr_valid) begin
      have_prev <= 1'b1; prev_addr <= wr_addr;
    end
  end

  a_r1_cond_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_evt && stop_evt));

  a_r1_release_on_cond: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt || stop_evt) |=> !sda_oe);

  a_r12_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_q);

  a_r6_commit_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> $past(stop_evt));

  a_r5_page_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && have_prev) |->
      (wr_addr[ADDR_W-1:PAGE_W] == prev_addr[ADDR_W-1:PAGE_W]) &&
      (wr_addr[PAGE_W-1:0] == PAGE_W'(prev_addr[PAGE_W-1:0] + 1'b1)));
endmodule

bind twi_mem_target twi_mem_target_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .start_evt(start_evt),
  .stop_evt(stop_evt), .sda_oe(sda_oe), .wr_valid(wr_valid),
  .wr_addr(wr_addr), .wr_commit(wr_commit)
);

// File: tb/twi_mem_target_bench.sv
module twi_mem_target_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 5;
  localparam int BUSY_CYC = 400;
  localparam logic [1:0] STRAP = 2'b10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, host_sda = 1'b1;
  logic busy_i = 1'b0;
  logic sda_oe, wr_valid, wr_commit;
  logic [14:0] rd_addr, wr_addr;
  logic [7:0] rd_data = 8'h00, wr_data;
  wire sda_bus = host_sda & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  twi_mem_target u_twi_mem_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .strap_i(STRAP),
    .busy_i(busy_i), .sda_oe(sda_oe), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit)
  );

  int tests = 0, fails = 0;
  logic [7:0] ram [int];
  logic [7:0] model [int];
  logic [22:0] pend_q [$];
  logic [22:0] exp_wr [$];
  logic [7:0] exp_rd [$], got_rd [$];
  string rd_tag [$];
  logic [14:0] bptr = '0;
  int busy_cnt = 0;
  logic oe_after;

  function automatic logic [7:0] dflt(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
  endfunction
  function automatic logic [7:0] ram_get(input logic [14:0] a);
    return ram.exists(int'(a)) ? ram[int'(a)] : dflt(a);
  endfunction
  function automatic logic [7:0] model_get(input logic [14:0] a);
    return model.exists(int'(a)) ? model[int'(a)] : dflt(a);
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // RAM behind the read port and page-write unit model
  always @(posedge clk) rd_data <= ram_get(rd_addr);

  always @(negedge clk) begin
    if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
    busy_i <= (busy_cnt > 1);
    if (wr_valid) begin
      pend_q.push_back({wr_addr, wr_data});
      if (exp_wr.size() == 0) check(1'b0, "R5 unexpected write", int'({wr_addr, wr_data}), 0);
      else begin
        logic [22:0] e;
        e = exp_wr.pop_front();
        check({wr_addr, wr_data} == e, "R5 write addr/data", int'({wr_addr, wr_data}), int'(e));
      end
    end
    if (wr_commit) begin
      while (pend_q.size() > 0) begin
        logic [22:0] p;
        p = pend_q.pop_front();
        ram[int'(p[22:8])] = p[7:0];
      end
      busy_cnt <= BUSY_CYC;
      busy_i <= 1'b1;
    end
  end

  // read scoreboard monitor
  always @(negedge clk) begin
    while (exp_rd.size() > 0 && got_rd.size() > 0) begin
      logic [7:0] e, g;
      string t;
      e = exp_rd.pop_front(); g = got_rd.pop_front(); t = rd_tag.pop_front();
      check(g == e, t, g, e);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bit_out(input logic b);
    tick(Q); host_sda = b; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    tick(Q); host_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q); b = sda_bus; tick(Q); scl = 1'b0;
  endtask

  task automatic do_start();
    tick(Q); host_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q); host_sda = 1'b0; tick(Q); scl = 1'b0;
  endtask

  task automatic do_stop();
    tick(Q); host_sda = 1'b0; tick(Q); scl = 1'b1; tick(Q); host_sda = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(s);
    ack = !s;
    tick(6);
    oe_after = sda_oe;
  endtask

  task automatic recv_byte(input logic host_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      logic s;
      bit_in(s);
      b[i] = s;
    end
    bit_out(!host_ack);
    host_sda = 1'b1;
  endtask

  function automatic logic [7:0] dev(input logic rd);
    return {4'b1010, 1'b0, STRAP, rd};
  endfunction

  task automatic do_write(input logic [7:0] hi, input logic [7:0] lo, input logic [7:0] d [$]);
    logic ack;
    logic [14:0] a;
    do_start();
    send_byte(dev(1'b0), ack); check(ack, "R2 write device ack", ack, 1);
    send_byte(hi, ack); check(ack, "R4 high address ack", ack, 1);
    send_byte(lo, ack); check(ack, "R3 low address ack", ack, 1);
    a = {hi[6:0], lo};
    foreach (d[k]) begin
      exp_wr.push_back({a, d[k]});
      model[int'(a)] = d[k];
      a = {a[14:6], 6'(a[5:0] + 6'd1)};
      send_byte(d[k], ack); check(ack, "R5 data ack", ack, 1);
    end
    bptr = a;
    do_stop();
  endtask

  task automatic read_cur(input int n, input string tag);
    logic ack;
    logic [7:0] b;
    do_start();
    send_byte(dev(1'b1), ack); check(ack, {tag, " read device ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      exp_rd.push_back(model_get(bptr)); rd_tag.push_back(tag);
      bptr = bptr + 15'd1;
      recv_byte(k < n - 1, b);
      got_rd.push_back(b);
    end
  endtask

  task automatic set_ptr(input logic [7:0] hi, input logic [7:0] lo);
    logic ack;
    do_start();
    send_byte(dev(1'b0), ack); check(ack, "R10 setup device ack", ack, 1);
    send_byte(hi, ack);
    send_byte(lo, ack); check(ack, "R10 setup address ack", ack, 1);
    bptr = {hi[6:0], lo};
  endtask

  task automatic wait_ready();
    logic ack;
    ack = 1'b0;
    for (int t = 0; t < 30 && !ack; t++) begin
      do_start();
      send_byte(dev(1'b0), ack);
      do_stop();
    end
    check(ack, "R11 poll acknowledged after busy", ack, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] b;
    logic [7:0] d [$];
    tick(5);
    rst_n = 1'b1;
    tick(5);
    check(sda_oe == 1'b0, "R3 reset sda_oe", sda_oe, 0);
    check(wr_valid == 1'b0, "R5 reset wr_valid", wr_valid, 0);
    check(wr_commit == 1'b0, "R6 reset wr_commit", wr_commit, 0);

    // R2: wrong strap is not acknowledged, and later bytes are ignored
    do_start();
    send_byte({4'b1010, 1'b0, 2'b01, 1'b0}, ack); check(!ack, "R2 strap mismatch nack", ack, 0);
    send_byte(dev(1'b0), ack); check(!ack, "R2 ignored until start", ack, 0);
    do_stop();
    send_byte({4'b1110, 1'b0, STRAP, 1'b0}, ack);
    do_start();
    send_byte({4'b1110, 1'b0, STRAP, 1'b0}, ack); check(!ack, "R2 wrong tag nack", ack, 0);
    do_stop();

    // R1: start mid-byte restarts device address
    do_start();
    for (int i = 0; i < 4; i++) bit_out(i[0]);
    do_start();
    send_byte(dev(1'b0), ack); check(ack, "R1 start mid-byte resync", ack, 1);
    check(oe_after == 1'b0, "R3 ack released after ninth clock", oe_after, 0);
    do_stop();
    // R1: stop mid-byte returns to ignoring the bus
    do_start();
    for (int i = 0; i < 3; i++) bit_out(1'b1);
    do_stop();
    send_byte(dev(1'b0), ack); check(!ack, "R1 stop mid-byte ignores bus", ack, 0);
    do_stop();

    // R5 R6: write three bytes; R11 busy polling
    d = '{8'h11, 8'h22, 8'h33};
    do_write(8'h12, 8'h34, d);
    tick(4);
    do_start();
    send_byte(dev(1'b1), ack); check(!ack, "R11 busy read poll nack", ack, 0);
    do_stop();
    wait_ready();

    // R10 R8: random read with sequential continuation, host nack ends
    set_ptr(8'h12, 8'h34);
    read_cur(3, "R10 random read");
    // R9: further clocks after host nack read back as ones
    for (int i = 7; i >= 0; i--) begin logic s; bit_in(s); b[i] = s; end
    check(b == 8'hFF, "R9 released after host nack", b, 8'hFF);
    do_stop();

    // R7: current read continues after last accessed
    read_cur(2, "R7 current read");
    do_stop();

    // R6: address-only transaction does not commit
    set_ptr(8'h00, 8'h40);
    do_stop();
    tick(4);
    check(busy_i == 1'b0, "R6 no commit without data", busy_i, 0);

    // R5: page wrap during write
    d = '{8'hA1, 8'hA2, 8'hA3, 8'hA4};
    do_write(8'h0A, 8'h3E, d);
    check(bptr == 15'h0A02, "R5 bench pointer after wrap", bptr, 15'h0A02);
    wait_ready();
    set_ptr(8'h0A, 8'h00);
    read_cur(2, "R5 page wrap readback");
    do_stop();
    read_cur(1, "R7 pointer after read");
    do_stop();

    // R8: read wrap across the top of the array
    set_ptr(8'h7F, 8'hFF);
    read_cur(3, "R8 array wrap");
    do_stop();

    // R4: high byte bit 7 ignored
    set_ptr(8'h81, 8'h00);
    check(bptr == 15'h0100, "R4 bench pointer", bptr, 15'h0100);
    read_cur(1, "R4 msb ignored");
    do_stop();

    tick(20);
    check(exp_rd.size() == 0, "R8 all reads scored", exp_rd.size(), 0);
    check(exp_wr.size() == 0, "R5 all writes seen", exp_wr.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule